// File: doc/BRIEF.md
# Serial Configuration Target with One-Frame-Late Readback

This block is a serial peripheral target that holds the configuration of a multi-channel pulse generator. A host sends 16-bit words, one per chip-select window, most significant bit first. The upper byte of each word holds a direction flag and a 7-bit register address. The lower byte holds the write value, or qualifiers when the word is a read. The block stores mode, output inversion, channel enables, per-channel frequency and duty codes and a watchdog setting. It drives these values onto plain output ports for the generator beside it.

Read results do not come back in the word that asked for them. The block stages the result when the request window closes and shifts it out during the next window. The result sits in the low 14 bits of that word and the top two bits are zero. The read qualifier picks the source. With the qualifier set, the block returns the addressed register. With it clear, the block returns a diagnostic status word taken from an input port. The serial pins are sampled by the system clock through synchronisers. Sampling happens on rising serial-clock edges and the output shifts on falling edges.

Top module: `spi_cfg_target`

## Requirements
- R1: A frame is the bits clocked between a falling and a rising edge of chip select (active low), MSB first. Bit 15 set means write and bit 15 clear means read. Bits 14:8 are the register address and bits 7:0 are the data or qualifier byte.
- R2: A valid write frame stores bits 7:0 into the addressed register. The new value appears on the matching output port once chip select has risen.
- R3: The register map is: 0x00 global control, 0x05 inversion (bit n for channel n), 0x07 enables (bit 4+n for channel n), 0x08+n frequency code of channel n (byte n of `freq_cfg_o`), 0x0C+n duty code of channel n (byte n of `duty_cfg_o`), 0x14 watchdog.
- R4: `mode_o` is bits 7:6 of register 0x00. `normal_mode_o` is high exactly when that field is 1.
- R5: The response to a read is shifted out on `spi_miso_o` during the next frame, MSB first. Its data is in bits 13:0 and bits 15:14 are zero. `spi_miso_o` is low while chip select is high.
- R6: On a read, bit 7 of the qualifier byte selects the source. When set, the addressed register is returned, zero-extended. When clear, `diag_status_i` is returned as it stood when the request frame ended.
- R7: A read of an unmapped address returns zero. A write to an unmapped address changes no register.
- R8: A frame with any number of serial-clock rising edges other than 16 is discarded. It writes nothing and the next frame returns zero.
- R9: After a valid write frame, the next frame returns zero.
- R10: After reset every register is zero, `spi_miso_o` is low, and the first frame returns zero.
- R11: Register outputs change only at the end of a valid write frame to a mapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock, idle low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_miso_o | output | 1 | Serial data to host |
| diag_status_i | input | 14 | Status word returned by status reads |
| mode_o | output | 2 | Global mode field |
| normal_mode_o | output | 1 | High when mode field equals 1 |
| invert_o | output | 4 | Per-channel output inversion |
| chan_en_o | output | 4 | Per-channel enable |
| freq_cfg_o | output | 32 | Frequency codes, byte n for channel n |
| duty_cfg_o | output | 32 | Duty codes, byte n for channel n |
| wdog_cfg_o | output | 8 | Watchdog setting |

## Verification
The hardest case to reach is a frame that is cut short or runs long while a read result is already staged. To show the discard, that staged result must be lost and the register contents must stay intact. The stimulus first stages a known non-zero result with a control read. It then sends a 12-edge frame and a 20-edge frame, each carrying a well-formed write to the inversion register. After each bad frame the bench checks the inversion output and the next response word. A second hard case is the timing of the status capture. The bench changes the status input after a status request has closed and confirms that the earlier value is the one that comes back.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

   // Register addresses; the per-channel banks are contiguous from their base.
   localparam int ADDR_GLOBAL = 'h00;
   localparam int ADDR_INVERT = 'h05;
   localparam int ADDR_ENABLE = 'h07;
   localparam int ADDR_FREQ0  = 'h08;
   localparam int ADDR_DUTY0  = 'h0C;
   localparam int ADDR_WDOG   = 'h14;

   // Bit position of channel 0 inside the enable register.
   localparam int ENA_BIT_OFS = 4;

   // Mode field location inside the global register and the normal code.
   localparam int MODE_LSB = 6;
   localparam int MODE_W   = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_IDLE   = 2'd0,
      MODE_NORMAL = 2'd1,
      MODE_RSVD2  = 2'd2,
      MODE_RSVD3  = 2'd3
   } op_mode_e;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cfg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= din;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_s,
   input  logic               mosi_s,
   input  logic               csn_s,
   input  logic [FRAME_W-1:0] resp_i,
   output logic               miso_o,
   output logic               frame_done_o,
   output logic               frame_ok_o,
   output logic [FRAME_W-1:0] rx_word_o
);

   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam int CNT_MAX = FRAME_W + 1;

   if (FRAME_W < 2) begin : g_bad_frame
      $error("spi_cfg_shifter: FRAME_W too small");
   end

   logic               sck_q, csn_q;
   logic [FRAME_W-1:0] rx_q, tx_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               done_q, ok_q;

   logic sck_rise, sck_fall, sel, cs_start, cs_end;

   always_comb begin
      sck_rise = sck_s & ~sck_q;
      sck_fall = ~sck_s & sck_q;
      sel      = ~csn_s;
      cs_start = ~csn_s & csn_q;
      cs_end   = csn_s & ~csn_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         csn_q  <= 1'b1;
         rx_q   <= '0;
         tx_q   <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         sck_q  <= sck_s;
         csn_q  <= csn_s;
         done_q <= 1'b0;
         if (cs_start) begin
            cnt_q <= '0;
            rx_q  <= '0;
            tx_q  <= resp_i;
         end else if (sel) begin
            if (sck_rise) begin
               rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
               if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
            if (sck_fall && cnt_q != '0) begin
               tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
         end
         if (cs_end) begin
            done_q <= 1'b1;
            ok_q   <= (cnt_q == CNT_W'(FRAME_W));
         end
      end
   end

   assign miso_o       = tx_q[FRAME_W-1] & ~csn_q;
   assign frame_done_o = done_q;
   assign frame_ok_o   = ok_q;
   assign rx_word_o    = rx_q;

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
   import spi_cfg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       rd_hit,
   output logic [DATA_W-1:0]          glob_o,
   output logic [DATA_W-1:0]          inv_o,
   output logic [DATA_W-1:0]          ena_o,
   output logic [DATA_W-1:0]          wdog_o,
   output logic [NUM_CH*DATA_W-1:0]   freq_o,
   output logic [NUM_CH*DATA_W-1:0]   duty_o
);

   // Slots: 0 global, 1 invert, 2 enable, 3 watchdog, then frequency, then duty.
   localparam int FIXED_SLOTS = 4;
   localparam int FREQ_SLOT0  = FIXED_SLOTS;
   localparam int DUTY_SLOT0  = FIXED_SLOTS + NUM_CH;
   localparam int NUM_REG     = FIXED_SLOTS + 2 * NUM_CH;

   function automatic logic [ADDR_W-1:0] slot_addr(input int s);
      int a;
      if (s == 0)               a = ADDR_GLOBAL;
      else if (s == 1)          a = ADDR_INVERT;
      else if (s == 2)          a = ADDR_ENABLE;
      else if (s == 3)          a = ADDR_WDOG;
      else if (s < DUTY_SLOT0)  a = ADDR_FREQ0 + (s - FREQ_SLOT0);
      else                      a = ADDR_DUTY0 + (s - DUTY_SLOT0);
      return ADDR_W'(a);
   endfunction

   logic [NUM_REG*DATA_W-1:0] regs_flat;

   for (genvar s = 0; s < NUM_REG; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = slot_addr(s);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (wr_en && wr_addr == SLOT_ADDR) q <= wr_data;
      end
      assign regs_flat[s*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data = '0;
      rd_hit  = 1'b0;
      for (int s = 0; s < NUM_REG; s++) begin
         if (rd_addr == slot_addr(s)) begin
            rd_data = regs_flat[s*DATA_W +: DATA_W];
            rd_hit  = 1'b1;
         end
      end
   end

   assign glob_o = regs_flat[0*DATA_W +: DATA_W];
   assign inv_o  = regs_flat[1*DATA_W +: DATA_W];
   assign ena_o  = regs_flat[2*DATA_W +: DATA_W];
   assign wdog_o = regs_flat[3*DATA_W +: DATA_W];
   assign freq_o = regs_flat[FREQ_SLOT0*DATA_W +: NUM_CH*DATA_W];
   assign duty_o = regs_flat[DUTY_SLOT0*DATA_W +: NUM_CH*DATA_W];

endmodule

// File: rtl/spi_cfg_target.sv
module spi_cfg_target
   import spi_cfg_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int DATA_W      = 8,
   parameter int RESP_DATA_W = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spi_sck_i,
   input  logic                     spi_mosi_i,
   input  logic                     spi_csn_i,
   output logic                     spi_miso_o,
   input  logic [RESP_DATA_W-1:0]   diag_status_i,
   output logic [MODE_W-1:0]        mode_o,
   output logic                     normal_mode_o,
   output logic [NUM_CH-1:0]        invert_o,
   output logic [NUM_CH-1:0]        chan_en_o,
   output logic [NUM_CH*DATA_W-1:0] freq_cfg_o,
   output logic [NUM_CH*DATA_W-1:0] duty_cfg_o,
   output logic [DATA_W-1:0]        wdog_cfg_o
);

   localparam int FRAME_W = 2 * DATA_W;
   localparam int ADDR_W  = DATA_W - 1;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("spi_cfg_target: NUM_CH must be 1..4");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("spi_cfg_target: DATA_W must be at least 8");
   end
   if (RESP_DATA_W < DATA_W || RESP_DATA_W > FRAME_W) begin : g_bad_resp
      $error("spi_cfg_target: RESP_DATA_W out of range");
   end

   // Synchronised serial pins: {csn, sck, mosi}.
   logic [2:0] pins_s;
   logic       csn_s, sck_s, mosi_s;

   spi_cfg_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({spi_csn_i, spi_sck_i, spi_mosi_i}),
      .dout  (pins_s)
   );

   assign {csn_s, sck_s, mosi_s} = pins_s;

   // Frame shifting.
   logic [FRAME_W-1:0] resp_q;
   logic [FRAME_W-1:0] rx_word;
   logic               frame_done, frame_ok;

   spi_cfg_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_s        (sck_s),
      .mosi_s       (mosi_s),
      .csn_s        (csn_s),
      .resp_i       (resp_q),
      .miso_o       (spi_miso_o),
      .frame_done_o (frame_done),
      .frame_ok_o   (frame_ok),
      .rx_word_o    (rx_word)
   );

   // Frame decode.
   logic [DATA_W-1:0] cmd_byte, arg_byte;
   logic              is_wr, ctrl_sel, wr_en;
   logic [ADDR_W-1:0] addr;

   always_comb begin
      cmd_byte = rx_word[FRAME_W-1 -: DATA_W];
      arg_byte = rx_word[DATA_W-1:0];
      is_wr    = cmd_byte[DATA_W-1];
      addr     = cmd_byte[ADDR_W-1:0];
      ctrl_sel = arg_byte[DATA_W-1];
      wr_en    = frame_done & frame_ok & is_wr;
   end

   // Register storage.
   logic [DATA_W-1:0] rd_data, glob_reg, inv_reg, ena_reg;
   logic              rd_hit;

   spi_cfg_regfile #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (addr),
      .wr_data (arg_byte),
      .rd_addr (addr),
      .rd_data (rd_data),
      .rd_hit  (rd_hit),
      .glob_o  (glob_reg),
      .inv_o   (inv_reg),
      .ena_o   (ena_reg),
      .wdog_o  (wdog_cfg_o),
      .freq_o  (freq_cfg_o),
      .duty_o  (duty_cfg_o)
   );

   // Response staging for the following frame.
   logic [RESP_DATA_W-1:0] resp_payload;
   logic [FRAME_W-1:0]     resp_next;

   always_comb begin
      resp_payload = '0;
      if (ctrl_sel) resp_payload[DATA_W-1:0] = rd_data;
      else          resp_payload = diag_status_i;
      resp_next = '0;
      if (frame_ok && !is_wr && rd_hit) resp_next[RESP_DATA_W-1:0] = resp_payload;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          resp_q <= '0;
      else if (frame_done) resp_q <= resp_next;
   end

   // Field extraction toward the pulse generator.
   op_mode_e mode_field;
   assign mode_field    = op_mode_e'(glob_reg[MODE_LSB +: MODE_W]);
   assign mode_o        = mode_field;
   assign normal_mode_o = (mode_field == MODE_NORMAL);
   assign invert_o      = inv_reg[NUM_CH-1:0];
   assign chan_en_o     = ena_reg[ENA_BIT_OFS +: NUM_CH];

   logic unused_bits;
   assign unused_bits = ^{glob_reg, inv_reg, ena_reg};

endmodule

// File: rtl/spi_cfg_target_chk.sv
module spi_cfg_target_chk #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     frame_done,
   input logic                     frame_ok,
   input logic [2*DATA_W-1:0]      rx_word,
   input logic [2*DATA_W-1:0]      resp_q,
   input logic [1:0]               mode_o,
   input logic [NUM_CH-1:0]        invert_o,
   input logic [NUM_CH-1:0]        chan_en_o,
   input logic [NUM_CH*DATA_W-1:0] freq_cfg_o,
   input logic [NUM_CH*DATA_W-1:0] duty_cfg_o,
   input logic [DATA_W-1:0]        wdog_cfg_o
);

   localparam int FW = 2 * DATA_W;
   localparam logic [DATA_W-1:0] WR_GLOBAL = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] WR_INVERT = WR_GLOBAL | DATA_W'(5);
   localparam logic [DATA_W-1:0] RD_WDOG   = DATA_W'(8'h14);

   logic [DATA_W-1:0] cmd;
   logic              good_wr, good_rd;
   logic [2 + 2*NUM_CH + 2*NUM_CH*DATA_W + DATA_W - 1:0] cfg;

   assign cmd     = rx_word[FW-1 -: DATA_W];
   assign good_wr = frame_done && frame_ok && cmd[DATA_W-1];
   assign good_rd = frame_done && frame_ok && !cmd[DATA_W-1];
   assign cfg     = {mode_o, invert_o, chan_en_o, freq_cfg_o, duty_cfg_o, wdog_cfg_o};

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !good_wr |=> $stable(cfg));

   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_ok) |=> (resp_q == '0));

   p_wresp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |=> (resp_q == '0));

   p_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && cmd == WR_GLOBAL) |=> (mode_o == $past(rx_word[DATA_W-1 -: 2])));

   p_invert_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && cmd == WR_INVERT) |=> (invert_o == $past(rx_word[NUM_CH-1:0])));

   p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && cmd[DATA_W-2:0] > (DATA_W-1)'(8'h14)) |=> $stable(cfg));

   p_ctrl_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (good_rd && cmd == RD_WDOG && rx_word[DATA_W-1]) |=> (resp_q == FW'($past(wdog_cfg_o))));

endmodule

bind spi_cfg_target spi_cfg_target_chk #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_done (frame_done),
   .frame_ok   (frame_ok),
   .rx_word    (rx_word),
   .resp_q     (resp_q),
   .mode_o     (mode_o),
   .invert_o   (invert_o),
   .chan_en_o  (chan_en_o),
   .freq_cfg_o (freq_cfg_o),
   .duty_cfg_o (duty_cfg_o),
   .wdog_cfg_o (wdog_cfg_o)
);

// File: tb/tb_spi_cfg_target.sv
module tb_spi_cfg_target;

   localparam int HALF = 6;
   localparam int NV   = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, mosi = 1'b0, csn = 1'b1;
   logic        miso;
   logic [13:0] diag = 14'h2A5C;
   logic [1:0]  mode;
   logic        normal;
   logic [3:0]  inv, ena;
   logic [31:0] freq, duty;
   logic [7:0]  wdog;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   spi_cfg_target dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .spi_sck_i     (sck),
      .spi_mosi_i    (mosi),
      .spi_csn_i     (csn),
      .spi_miso_o    (miso),
      .diag_status_i (diag),
      .mode_o        (mode),
      .normal_mode_o (normal),
      .invert_o      (inv),
      .chan_en_o     (ena),
      .freq_cfg_o    (freq),
      .duty_cfg_o    (duty),
      .wdog_cfg_o    (wdog)
   );

   // {word sent, word expected back in the same frame}
   localparam logic [31:0] VEC [NV] = '{
      {16'h850A, 16'h0000},   // R10 first response zero; write invert
      {16'h8750, 16'h0000},   // R9 write enable
      {16'h0580, 16'h0000},   // R9 read invert (ctrl)
      {16'h0780, 16'h000A},   // R5 invert data one frame late
      {16'h883C, 16'h0050},   // R6 enable contents
      {16'h0880, 16'h0000},   // R9
      {16'h0C00, 16'h003C},   // R3 freq ch0; status read of duty0
      {16'h1580, 16'h2A5C},   // R6 status word
      {16'h8040, 16'h0000},   // R7 unmapped read -> zero; mode normal
      {16'h0080, 16'h0000},   // R9
      {16'h94C3, 16'h0040},   // R4 global readback; write watchdog
      {16'h8FFF, 16'h0000},   // R9 write duty ch3
      {16'h1480, 16'h0000},   // R9
      {16'h0F80, 16'h00C3},   // R3 watchdog readback
      {16'h9577, 16'h00FF},   // R3 duty3 readback; unmapped write
      {16'h0080, 16'h0000},   // R9
      {16'h0580, 16'h0040}    // R7 global unchanged by unmapped write
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] tx, input int nbits, output logic [15:0] rx);
      rx = '0;
      @(negedge clk) csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx  = {rx[14:0], miso};
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      csn  = 1'b1;
      mosi = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] rx;
      logic [31:0] snap;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10 reset state
      chk({mode, normal, inv, ena, wdog} == '0, "R10 regs reset", {mode, normal, inv, ena, wdog}, 0);
      chk(freq == 0 && duty == 0, "R10 banks reset", freq | duty, 0);
      chk(miso == 1'b0, "R10 miso idle", miso, 0);

      for (int v = 0; v < NV; v++) begin
         xfer({16'h0, VEC[v][31:16]}, 16, rx);
         chk(rx == VEC[v][15:0], $sformatf("R5 vector %0d", v), rx, VEC[v][15:0]);
         chk(miso == 1'b0, "R5 miso low when deselected", miso, 0);
      end

      chk(inv == 4'hA, "R2 invert", inv, 4'hA);
      chk(ena == 4'h5, "R3 enable bits 4+n", ena, 4'h5);
      chk(freq == 32'h0000003C, "R3 freq ch0", freq, 32'h3C);
      chk(duty == 32'hFF000000, "R3 duty ch3", duty, 32'hFF000000);
      chk(wdog == 8'hC3, "R7 watchdog kept after unmapped write", wdog, 8'hC3);
      chk(mode == 2'd1 && normal, "R4 normal mode", {normal, mode}, 3'b101);
      chk(wdog == 8'hC3 && inv == 4'hA, "R11 unchanged by reads", {wdog, inv}, 12'hC3A);

      // R1 R8 short frame discarded, staged result (0x000A) dropped
      xfer(32'h00000850, 12, rx);
      chk(inv == 4'hA, "R8 short frame no write", inv, 4'hA);
      xfer(32'h00000780, 16, rx);
      chk(rx == 16'h0000, "R8 response after short frame", rx, 0);

      // R8 long frame
      xfer(32'h00085030, 20, rx);
      chk(inv == 4'hA, "R8 long frame no write", inv, 4'hA);
      xfer(32'h00000C00, 16, rx);
      chk(rx == 16'h0000, "R8 response after long frame", rx, 0);

      // R6 status captured at end of request frame
      diag = 14'h0777;
      xfer(32'h00000C00, 16, rx);
      diag = 14'h1234;
      snap = {28'h0, inv};
      xfer(32'h00008080, 16, rx);
      chk(rx == 16'h0777, "R6 status sampled at request end", rx, 16'h0777);
      chk(mode == 2'd2 && !normal, "R4 non-normal mode", {normal, mode}, 3'b010);
      chk({28'h0, inv} == snap, "R11 invert untouched by global write", {28'h0, inv}, snap);
      xfer(32'h00000080, 16, rx);
      chk(rx == 16'h0000, "R9 response after write", rx, 0);
      xfer(32'h00000000, 16, rx);
      chk(rx == 16'h0080, "R1 R5 global readback", rx, 16'h0080);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule